// File: doc/BRIEF.md
# Cascadable Eight-Line Priority Interrupt Controller

The controller collects interrupt requests on eight numbered lines. Each request arrives as a one-cycle event that names a line. A request that is not masked is latched in a request register. The controller raises a one-cycle interrupt pulse toward the processor, or toward a master controller, when no line of equal or higher number is still being serviced.

When the processor acknowledges, the highest-numbered pending line wins. That line moves from the request register to the in-service register, and an 8-bit vector comes back one cycle later. The vector is normally a programmable base with the line number in its low three bits. If the winning line is configured as a cascade input and a slave is present, the acknowledge is passed on to the slave, and the slave's vector is returned in the same cycle slot.

A two-address byte port serves software:
- Offset 1 holds the mask.
- Offset 0 takes commands: end-of-interrupt and selection of the register that reads back.
- Offset 0 reads back either the request or the in-service register.

Top module: `irq_ctl`

## Requirements
- R1: A request event whose 4-bit line number is 8 or above pulses `err_o` in the next cycle. It changes no register and does not pulse `irq_o`.
- R2: A request on a line whose mask bit is 1 changes no register and does not pulse `irq_o`.
- R3: An unmasked request on line n (0..7) sets request bit n in the next cycle.
- R4: An unmasked request on line n pulses `irq_o` for one cycle, in the cycle after the request, only if in-service bits n..7 are all zero. Otherwise the request only stays pending.
- R5: An acknowledge with requests pending takes the highest set request bit. That bit is cleared, the matching in-service bit is set, and `vec_valid_o` pulses in the next cycle with the vector on `vec_o`.
- R6: If the winning line's bit in `casc_map_i` is 1 and `slave_present_i` is 1, `casc_ack_o` is high during the acknowledge cycle. The returned vector is then `casc_vec_i`, taken in the cycle of `vec_valid_o`.
- R7: A vector produced locally equals `{vec_base_i, line[2:0]}`.
- R8: A write to offset 1 loads the mask, and a read at offset 1 returns it. Reads at offset 0 return the request register or the in-service register. Writing 0x0B to offset 0 selects the in-service register and writing 0x0A selects the request register. After reset the request register is selected.
- R9: After reset the request, in-service and mask registers read 0, and `irq_o`, `err_o` and `vec_valid_o` are low.
- R10: Writing 0x20 to offset 0 clears the highest set in-service bit. One cycle after that clear takes effect, `irq_o` pulses if some pending request bit n has in-service bits n..7 all zero.
- R11: Events in the same cycle merge.
  - A request arriving with an acknowledge does not take part in that acknowledge, but is kept in the request register.
  - An end-of-interrupt arriving with an acknowledge clears the old top in-service bit and sets the new winner's bit.
- R12: An acknowledge with no request pending returns `{vec_base_i, 3'd7}`, leaves the in-service register unchanged and does not assert `casc_ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request event strobe |
| req_line_i | input | 4 | Line number of the request event |
| irq_o | output | 1 | One-cycle interrupt pulse |
| err_o | output | 1 | One-cycle pulse for an out-of-range line number |
| ack_i | input | 1 | Acknowledge strobe |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Returned vector |
| casc_ack_o | output | 1 | Acknowledge forwarded to the slave |
| casc_vec_i | input | 8 | Vector supplied by the slave |
| casc_map_i | input | 8 | Lines that carry a slave |
| slave_present_i | input | 1 | A slave is attached |
| vec_base_i | input | 5 | Upper five bits of local vectors |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
Two pairs of events can land in the same cycle: an acknowledge with a new request, and an acknowledge with an end-of-interrupt write. The bench drives each pair in a single step.
- For the request pair, it checks that the winner is taken from the old request register, and that the new request stays pending and still pulses `irq_o`.
- For the end-of-interrupt pair, it checks that the in-service register drops the old top bit and gains the new winner in one update.

A two-controller cascade checks that a slave request yields the slave's vector through the master.

// File: rtl/irq_ctl_pkg.sv
// Package: shared sizes and command codes for the interrupt controller.
// Assumes a fixed count of eight lines and byte-wide registers.
package irq_ctl_pkg;
    localparam int NUM_LINES = 8;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int REQ_W     = IDX_W + 1;
    localparam int DATA_W    = 8;
    localparam int BASE_W    = DATA_W - IDX_W;

    localparam logic [DATA_W-1:0] CMD_EOI     = 8'h20;
    localparam logic [DATA_W-1:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [DATA_W-1:0] CMD_SEL_ISR = 8'h0B;

    typedef enum logic {
        SEL_REQ = 1'b0,
        SEL_SVC = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Finds the highest set bit of a vector. Assumes N is at least 2.
// The index output is 0 when no bit is set; any_o tells the two cases apart.
module irq_prio_enc #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    // Scan upward so that the last (highest) set bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) idx_o = W'(i);
        end
    end

    // Any bit set.
    assign any_o = |bits_i;
endmodule

// File: rtl/irq_isr_gate.sv
// Module: irq_isr_gate
// For every line n, reports whether in-service bits n..N-1 are all clear.
// Assumes the highest line has the highest priority.
module irq_isr_gate #(
    parameter int N = 8
) (
    input  logic [N-1:0] isr_i,
    output logic [N-1:0] open_o
);
    for (genvar g = 0; g < N; g++) begin : g_open
        // Line g is open when no line at or above g is in service.
        assign open_o[g] = ~|isr_i[N-1:g];
    end
endmodule

// File: rtl/irq_ctl.sv
// Module: irq_ctl
// Eight-line priority interrupt controller with a request register, an
// in-service register and a mask register.
// - The highest line wins an acknowledge.
// - Lines configured as cascade inputs take their vector from a slave.
// Assumes single-cycle strobes and a slave whose vector is registered one
// cycle after its acknowledge.
module irq_ctl
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [REQ_W-1:0]  req_line_i,
    output logic              irq_o,
    output logic              err_o,
    input  logic              ack_i,
    output logic              vec_valid_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              casc_ack_o,
    input  logic [DATA_W-1:0] casc_vec_i,
    input  logic [NUM_LINES-1:0] casc_map_i,
    input  logic              slave_present_i,
    input  logic [BASE_W-1:0] vec_base_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o
);
    logic [NUM_LINES-1:0] irr_q, isr_q, imr_q;
    rd_sel_e              rd_sel_q;
    logic                 eoi_pend_q, irq_q, err_q, vv_q, from_slave_q;
    logic [DATA_W-1:0]    lvec_q;

    logic                 in_range, req_ok;
    logic [IDX_W-1:0]     req_idx;
    logic [NUM_LINES-1:0] req_bit, win_bit, eoi_bit, open_w;
    logic                 irr_any, isr_any, ack_take, to_slave;
    logic                 wr_cmd, eoi_wr;
    logic [IDX_W-1:0]     win_idx, isr_top;
    logic                 irq_d;
    logic [DATA_W-1:0]    lvec_d;

    // Winner among pending requests.
    irq_prio_enc #(.N(NUM_LINES)) u_win_enc (
        .bits_i (irr_q),
        .any_o  (irr_any),
        .idx_o  (win_idx)
    );

    // Top in-service bit, the target of an end-of-interrupt.
    irq_prio_enc #(.N(NUM_LINES)) u_svc_enc (
        .bits_i (isr_q),
        .any_o  (isr_any),
        .idx_o  (isr_top)
    );

    // Per-line blocking by lines in service at or above.
    irq_isr_gate #(.N(NUM_LINES)) u_gate (
        .isr_i  (isr_q),
        .open_o (open_w)
    );

    // Request decode: range check, masking and line bit.
    always_comb begin
        in_range = (req_line_i < REQ_W'(NUM_LINES));
        req_idx  = req_line_i[IDX_W-1:0];
        req_ok   = req_valid_i && in_range && !imr_q[req_idx];
        req_bit  = req_ok ? (NUM_LINES'(1) << req_idx) : '0;
    end

    // Acknowledge decode: winner bit, cascade forwarding and local vector.
    always_comb begin
        ack_take = ack_i && irr_any;
        win_bit  = ack_take ? (NUM_LINES'(1) << win_idx) : '0;
        to_slave = ack_take && casc_map_i[win_idx] && slave_present_i;
        lvec_d   = {vec_base_i, (ack_take ? win_idx : IDX_W'(NUM_LINES - 1))};
    end

    // Command decode on the register port.
    always_comb begin
        wr_cmd  = reg_wr_i && !reg_addr_i;
        eoi_wr  = wr_cmd && (reg_wdata_i == CMD_EOI);
        eoi_bit = (eoi_wr && isr_any) ? (NUM_LINES'(1) << isr_top) : '0;
    end

    // Pulse on a fresh open request, or re-check pending bits after an end-of-interrupt.
    assign irq_d = (req_ok && open_w[req_idx]) ||
                   (eoi_pend_q && |(irr_q & open_w));

    // Core register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q        <= '0;
            isr_q        <= '0;
            imr_q        <= '0;
            rd_sel_q     <= SEL_REQ;
            eoi_pend_q   <= 1'b0;
            irq_q        <= 1'b0;
            err_q        <= 1'b0;
            vv_q         <= 1'b0;
            from_slave_q <= 1'b0;
            lvec_q       <= '0;
        end else begin
            irr_q        <= (irr_q & ~win_bit) | req_bit;
            isr_q        <= (isr_q & ~eoi_bit) | win_bit;
            eoi_pend_q   <= eoi_wr && isr_any;
            irq_q        <= irq_d;
            err_q        <= req_valid_i && !in_range;
            vv_q         <= ack_i;
            from_slave_q <= to_slave;
            lvec_q       <= lvec_d;
            if (reg_wr_i && reg_addr_i) imr_q <= reg_wdata_i;
            if (wr_cmd && reg_wdata_i == CMD_SEL_IRR) rd_sel_q <= SEL_REQ;
            if (wr_cmd && reg_wdata_i == CMD_SEL_ISR) rd_sel_q <= SEL_SVC;
        end
    end

    // Output drive and register read mux.
    assign irq_o       = irq_q;
    assign err_o       = err_q;
    assign vec_valid_o = vv_q;
    assign vec_o       = from_slave_q ? casc_vec_i : lvec_q;
    assign casc_ack_o  = to_slave;
    assign reg_rdata_o = reg_addr_i ? imr_q :
                         (rd_sel_q == SEL_SVC) ? isr_q : irr_q;
endmodule

// File: rtl/irq_ctl_chk.sv
// Module: irq_ctl_chk
// Temporal checks for irq_ctl, bound to every instance of it.
// Assumes access to the register state through the bind port list.
module irq_ctl_chk
    import irq_ctl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid_i,
    input logic [REQ_W-1:0]     req_line_i,
    input logic                 ack_i,
    input logic                 reg_wr_i,
    input logic                 reg_addr_i,
    input logic [DATA_W-1:0]    reg_wdata_i,
    input logic                 err_o,
    input logic                 vec_valid_o,
    input logic                 casc_ack_o,
    input logic [NUM_LINES-1:0] irr_q,
    input logic [NUM_LINES-1:0] isr_q,
    input logic [NUM_LINES-1:0] imr_q,
    input logic [IDX_W-1:0]     win_idx,
    input logic                 irr_any
);
    logic in_rng;
    logic eoi_w;
    assign in_rng = req_line_i < REQ_W'(NUM_LINES);
    assign eoi_w  = reg_wr_i && !reg_addr_i && (reg_wdata_i == CMD_EOI);

    AST_BAD_LINE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !in_rng) |=> err_o);   // R1

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && in_rng && imr_q[req_line_i[IDX_W-1:0]] && !ack_i)
        |=> (irr_q == $past(irr_q)));   // R2

    AST_UNMASKED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && in_rng && !imr_q[req_line_i[IDX_W-1:0]])
        |=> irr_q[$past(req_line_i[IDX_W-1:0])]);   // R3

    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irr_any && !req_valid_i)
        |=> (isr_q[$past(win_idx)] && !irr_q[$past(win_idx)]));   // R5

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_valid_o);   // R5

    AST_CASC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        casc_ack_o |-> (ack_i && irr_any));   // R6

    AST_SPURIOUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irr_any && !eoi_w) |=> (isr_q == $past(isr_q)));   // R12
endmodule

bind irq_ctl irq_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_line_i  (req_line_i),
    .ack_i       (ack_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .err_o       (err_o),
    .vec_valid_o (vec_valid_o),
    .casc_ack_o  (casc_ack_o),
    .irr_q       (irr_q),
    .isr_q       (isr_q),
    .imr_q       (imr_q),
    .win_idx     (win_idx),
    .irr_any     (irr_any)
);

// File: tb/irq_ctl_tb.sv
// Bench: a master and a slave controller. The slave's interrupt pulse feeds
// master line 2. Vectors are scoreboarded: the driver pushes expected values
// and a monitor pops them on every vec_valid_o of the master.
module irq_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Master stimulus.
    logic       m_valid = 0, m_ack = 0, m_wr = 0, m_addr = 0;
    logic [3:0] m_line = 0;
    logic [7:0] m_wdata = 0;
    // Slave stimulus.
    logic       s_valid = 0, s_wr = 0, s_addr = 0;
    logic [3:0] s_line = 0;
    logic [7:0] s_wdata = 0;

    logic       m_irq, m_err, m_vv, m_casc;
    logic [7:0] m_vec, m_rd;
    logic       s_irq, s_err, s_vv, s_casc;
    logic [7:0] s_vec, s_rd;

    logic       m_req_v;
    logic [3:0] m_req_l;
    assign m_req_v = m_valid | s_irq;
    assign m_req_l = s_irq ? 4'd2 : m_line;

    irq_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(m_req_v), .req_line_i(m_req_l),
        .irq_o(m_irq), .err_o(m_err), .ack_i(m_ack),
        .vec_valid_o(m_vv), .vec_o(m_vec), .casc_ack_o(m_casc),
        .casc_vec_i(s_vec), .casc_map_i(8'b0000_0100), .slave_present_i(1'b1),
        .vec_base_i(5'h04),
        .reg_wr_i(m_wr), .reg_addr_i(m_addr), .reg_wdata_i(m_wdata),
        .reg_rdata_o(m_rd)
    );

    irq_ctl u_slave (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(s_valid), .req_line_i(s_line),
        .irq_o(s_irq), .err_o(s_err), .ack_i(m_casc),
        .vec_valid_o(s_vv), .vec_o(s_vec), .casc_ack_o(s_casc),
        .casc_vec_i(8'h00), .casc_map_i(8'h00), .slave_present_i(1'b0),
        .vec_base_i(5'h0E),
        .reg_wr_i(s_wr), .reg_addr_i(s_addr), .reg_wdata_i(s_wdata),
        .reg_rdata_o(s_rd)
    );

    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each master vector.
    always @(negedge clk) begin
        if (rst_n && m_vv) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5: actual %h expected none", m_vec);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (m_vec !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, m_vec, e);
                end
            end
        end
    end

    // One master cycle: drive at a falling edge, return at the next falling edge.
    task automatic m_step(input logic v, input logic [3:0] l, input logic a,
                          input logic w, input logic ad, input logic [7:0] d);
        @(negedge clk);
        m_valid = v; m_line = l; m_ack = a; m_wr = w; m_addr = ad; m_wdata = d;
        @(negedge clk);
        m_valid = 0; m_ack = 0; m_wr = 0; m_addr = 0;
    endtask

    task automatic push(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Read a master register at the current falling edge.
    task automatic m_read(input logic ad, input logic [7:0] exp, input string t);
        m_addr = ad;
        #1;
        check(t, m_rd, exp);
        m_addr = 0;
    endtask

    task automatic m_read_isr(input logic [7:0] exp, input string t);
        m_step(0, 0, 0, 1, 0, 8'h0B);
        m_read(0, exp, t);
        m_step(0, 0, 0, 1, 0, 8'h0A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 irq", {7'd0, m_irq}, 8'h00);
        check("R9 err", {7'd0, m_err}, 8'h00);
        check("R9 vv", {7'd0, m_vv}, 8'h00);
        m_read(0, 8'h00, "R9 IRR");
        m_read(1, 8'h00, "R9 IMR");
        m_read_isr(8'h00, "R9 R8 ISR");

        // R3 R4 open request on line 3
        m_step(1, 4'd3, 0, 0, 0, 0);
        check("R4 irq line3", {7'd0, m_irq}, 8'h01);
        m_read(0, 8'h08, "R3 IRR line3");
        // R5 R7 acknowledge
        push(8'h23, "R7 vector line3");
        m_step(0, 0, 1, 0, 0, 0);
        m_read(0, 8'h00, "R5 IRR cleared");
        m_read_isr(8'h08, "R5 R8 ISR set");

        // R4 blocked lower request, then higher open request
        m_step(1, 4'd1, 0, 0, 0, 0);
        check("R4 blocked irq", {7'd0, m_irq}, 8'h00);
        m_read(0, 8'h02, "R3 IRR line1 pending");
        m_step(1, 4'd5, 0, 0, 0, 0);
        check("R4 higher irq", {7'd0, m_irq}, 8'h01);
        push(8'h25, "R5 highest wins");
        m_step(0, 0, 1, 0, 0, 0);
        m_read(0, 8'h02, "R5 IRR after");
        m_read_isr(8'h28, "R5 ISR two");

        // R10 end-of-interrupt with re-evaluation
        m_step(0, 0, 0, 1, 0, 8'h20);
        @(negedge clk);
        check("R10 still blocked", {7'd0, m_irq}, 8'h00);
        m_read_isr(8'h08, "R10 ISR top cleared");
        m_step(0, 0, 0, 1, 0, 8'h20);
        @(negedge clk);
        check("R10 re-eval irq", {7'd0, m_irq}, 8'h01);
        push(8'h21, "R7 vector line1");
        m_step(0, 0, 1, 0, 0, 0);
        m_step(0, 0, 0, 1, 0, 8'h20);
        @(negedge clk);
        m_read_isr(8'h00, "R10 ISR empty");

        // R2 R8 mask
        m_step(0, 0, 0, 1, 1, 8'h40);
        m_read(1, 8'h40, "R8 IMR readback");
        m_step(1, 4'd6, 0, 0, 0, 0);
        check("R2 masked irq", {7'd0, m_irq}, 8'h00);
        m_read(0, 8'h00, "R2 masked IRR");
        m_step(0, 0, 0, 1, 1, 8'h00);

        // R1 out of range
        m_step(1, 4'd9, 0, 0, 0, 0);
        check("R1 err", {7'd0, m_err}, 8'h01);
        check("R1 irq", {7'd0, m_irq}, 8'h00);
        m_read(0, 8'h00, "R1 IRR");
        m_step(1, 4'd15, 0, 0, 0, 0);
        check("R1 err 15", {7'd0, m_err}, 8'h01);

        // R12 spurious acknowledge
        push(8'h27, "R12 spurious vector");
        @(negedge clk);
        m_ack = 1;
        #1;
        check("R12 no casc", {7'd0, m_casc}, 8'h00);
        @(negedge clk);
        m_ack = 0;
        m_read_isr(8'h00, "R12 ISR unchanged");

        // R6 cascade through master line 2
        @(negedge clk);
        s_valid = 1; s_line = 4'd4;
        @(negedge clk);
        s_valid = 0;
        @(negedge clk);
        check("R6 master irq", {7'd0, m_irq}, 8'h01);
        m_read(0, 8'h04, "R6 master IRR");
        push(8'h74, "R6 slave vector");
        m_ack = 1;
        #1;
        check("R6 casc ack", {7'd0, m_casc}, 8'h01);
        @(negedge clk);
        m_ack = 0;
        s_wr = 1; s_wdata = 8'h0B;
        @(negedge clk);
        s_wr = 0;
        #1;
        check("R6 slave ISR", s_rd, 8'h10);
        s_wr = 1; s_wdata = 8'h20;
        @(negedge clk);
        s_wr = 0;
        m_step(0, 0, 0, 1, 0, 8'h20);
        @(negedge clk);

        // R11 acknowledge with a new request in the same cycle
        m_step(1, 4'd0, 0, 0, 0, 0);
        push(8'h20, "R11 old winner");
        m_step(1, 4'd6, 1, 0, 0, 0);
        check("R11 irq new req", {7'd0, m_irq}, 8'h01);
        m_read(0, 8'h40, "R11 IRR kept");
        m_read_isr(8'h01, "R11 ISR");
        // R11 acknowledge with end-of-interrupt in the same cycle
        push(8'h26, "R11 eoi+ack vector");
        m_step(0, 0, 1, 1, 0, 8'h20);
        m_read_isr(8'h40, "R11 ISR swap");
        m_read(0, 8'h00, "R11 IRR empty");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: actual %0d vectors missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule